// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a burst-capable memory. When an external controller accepts an access strobe, the sequencer loads the full start address. Each following clock edge that carries an active-low advance moves the burst one beat forward. Only the two least significant address bits change from beat to beat. The upper bits stay fixed for the whole burst.

A static order input selects how the two low bits move through the burst. In interleaved order, the low bits of beat k are the start low bits XORed with k. In linear order, they are the start low bits plus k, modulo four. After four advances the sequence wraps back to the start address. A beat index is output next to the address so that downstream logic can tell which beat is current. The accept signal is decoded outside this block. When accept and advance arrive together, accept wins.

Top module: `burst_addr_seq`

## Requirements
- R1: When `acc_ok` is 1 at a rising edge, `addr_out` equals the `addr_in` sampled at that edge from the next cycle on, and `beat_idx` is 0.
- R2: While `rst_n` is 0, `addr_out` is all zeros and `beat_idx` is 0.
- R3: With `order_sel` = 1 (interleaved), `addr_out[1:0]` at beat k equals the start low bits XOR k. Start 01 gives 01,00,11,10. Start 10 gives 10,11,00,01.
- R4: With `order_sel` = 0 (linear), `addr_out[1:0]` at beat k equals (start low bits + k) mod 4. Start 11 gives 11,00,01,10.
- R5: When `acc_ok` is 0 and `adv_n` is 1 at a rising edge, `addr_out` and `beat_idx` keep their values.
- R6: Four advances after a start return `addr_out` to the start address and `beat_idx` to 0.
- R7: An advance (`adv_n` = 0) in the same cycle as an accept has no effect. `beat_idx` is 0 and `addr_out` is the new start address.
- R8: Without an accept, bits `addr_out[ADDR_W-1:2]` never change.
- R9: Each edge with `acc_ok` = 0 and `adv_n` = 0 increments the 2-bit `beat_idx` by one, wrapping from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_ok | input | 1 | Accepted access strobe; loads a new start address |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_sel | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | Start address presented with the strobe |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
The order checks assume that `order_sel` is a strap. They relate two successive cycles of one burst through an invariant: the XOR of the low bits and the beat index for interleaved order, or their difference for linear order. The invariant only holds if the order does not change between those cycles. The stimulus therefore changes `order_sel` only on the same edge that accepts a new strobe, or while reset is held. The accept/advance priority check assumes nothing about `adv_n`. The stimulus drives `adv_n` low together with a strobe on purpose.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/burst_seq_state.sv
module burst_seq_state
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ok,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] start_q,
    output logic [BEAT_W-1:0] beat_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } seq_state_t;

    seq_state_t st_d, st_q;

    // Next-state: accept outranks advance
    always_comb begin
        st_d = st_q;
        if (acc_ok) begin
            st_d.start = addr_in;
            st_d.beat  = '0;
        end else if (!adv_n) begin
            st_d.beat  = st_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_q = st_q.start;
    assign beat_q  = st_q.beat;

endmodule

// File: rtl/burst_lowbit_map.sv
module burst_lowbit_map
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] seed,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] low_ilv;
    logic [BEAT_W-1:0] low_lin;

    assign low_ilv = seed ^ beat;
    assign low_lin = seed + beat;

    always_comb begin
        case (order_e'(order_sel))
            ORD_INTERLEAVE: low_out = low_ilv;
            default:        low_out = low_lin;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ok,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_bits;

    burst_seq_state #(.ADDR_W(ADDR_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_ok  (acc_ok),
        .adv_n   (adv_n),
        .addr_in (addr_in),
        .start_q (start_q),
        .beat_q  (beat_q)
    );

    burst_lowbit_map u_map (
        .seed      (start_q[BEAT_W-1:0]),
        .beat      (beat_q),
        .order_sel (order_sel),
        .low_out   (low_bits)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign addr_out = {start_q[ADDR_W-1:BEAT_W], low_bits};
        end else begin : g_lo_only
            assign addr_out = low_bits[ADDR_W-1:0];
        end
    endgenerate

    assign beat_idx = beat_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_ok,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx
);

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |=> (addr_out == $past(addr_in)) && (beat_idx == 2'd0)); // R1

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ok && adv_n) |=> ($stable(addr_out) && $stable(beat_idx))); // R5

    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ok && !adv_n) |=> (beat_idx == 2'($past(beat_idx) + 2'd1))); // R9

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]))); // R8

    AST_ILV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ok && order_sel) |=>
            ((addr_out[1:0] ^ beat_idx) == $past(addr_out[1:0] ^ beat_idx))); // R3

    AST_LIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ok && !order_sel) |=>
            (2'(addr_out[1:0] - beat_idx) == $past(2'(addr_out[1:0] - beat_idx)))); // R4

    AST_ACC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !adv_n) |=> (beat_idx == 2'd0)); // R7

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ok    (acc_ok),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .beat_idx  (beat_idx)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acc_ok;
    logic          adv_n;
    logic          order_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_ok    (acc_ok),
        .adv_n     (adv_n),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .beat_idx  (beat_idx)
    );

    // {order, start address, low bits of beats 0..3}
    localparam logic [18:0] VEC [8] = '{
        {1'b1, 10'h001, 8'b01_00_11_10},
        {1'b1, 10'h2AE, 8'b10_11_00_01},
        {1'b1, 10'h103, 8'b11_10_01_00},
        {1'b1, 10'h3FC, 8'b00_01_10_11},
        {1'b0, 10'h0F3, 8'b11_00_01_10},
        {1'b0, 10'h155, 8'b01_10_11_00},
        {1'b0, 10'h222, 8'b10_11_00_01},
        {1'b0, 10'h000, 8'b00_01_10_11}
    };

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, let one rising edge pass, sample at next negedge
    task automatic cycle(input logic acc, input logic adv, input logic [AW-1:0] a);
        acc_ok  = acc;
        adv_n   = adv;
        addr_in = a;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; acc_ok = 1'b0; adv_n = 1'b1; order_sel = 1'b1; addr_in = '0;
        @(negedge clk);
        cycle(1'b1, 1'b0, 10'h3FF); // ignored under reset
        check("R2 addr", addr_out, '0);
        check("R2 beat", AW'(beat_idx), '0);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            logic [AW-1:0] st;
            logic [7:0]    seq;
            order_sel = VEC[v][18];
            st  = VEC[v][17:8];
            seq = VEC[v][7:0];
            cycle(1'b1, 1'b1, st);
            check("R1 start addr", addr_out, st);
            check("R1 beat", AW'(beat_idx), '0);
            for (int k = 1; k < 4; k++) begin
                cycle(1'b0, 1'b0, ~st);
                check(order_sel ? "R3 R8 interleaved addr" : "R4 R8 linear addr",
                      addr_out, {st[AW-1:2], seq[7-2*k -: 2]});
                check("R9 beat", AW'(beat_idx), AW'(k));
            end
            cycle(1'b0, 1'b0, ~st);
            check("R6 wrap addr", addr_out, st);
            check("R6 wrap beat", AW'(beat_idx), '0);
        end

        // hold with advance high
        order_sel = 1'b0;
        cycle(1'b1, 1'b1, 10'h1A6);
        cycle(1'b0, 1'b0, 10'h000);
        for (int h = 0; h < 3; h++) begin
            cycle(1'b0, 1'b1, 10'h3FF);
            check("R5 hold addr", addr_out, 10'h1A7);
            check("R5 hold beat", AW'(beat_idx), 1);
        end

        // accept with advance low restarts mid-burst
        order_sel = 1'b1;
        cycle(1'b1, 1'b0, 10'h2C9);
        check("R7 accept addr", addr_out, 10'h2C9);
        check("R7 accept beat", AW'(beat_idx), 0);
        cycle(1'b0, 1'b0, 10'h000);
        check("R7 next beat addr", addr_out, 10'h2C8);

        finish_run();
    end

endmodule